// File: doc/BRIEF.md
# Round-Robin Set-Associative Cache Line Store

This block holds the tags, physical addresses, dirty state and data words of a set-associative cache. A combinational lookup port takes a virtual address and reports whether a valid line holds it, which way it sits in, and the whole line as a packed vector. A write port updates one word of a line that hits. In write-back builds it also marks the half of the line that holds that word as dirty.

Allocation takes a virtual and a physical address. The victim is picked by a rotating pointer that each set keeps for itself. In write-back builds, a victim that is valid and dirty first sends its dirty words out through a word-wide write-back handshake. The line is then refilled one 32-bit word at a time through a request/response read port. In write-through builds, allocation only rewrites the tag and the stored physical address. The surrounding cache controller issues lookups and allocations and owns the memory side.

Top module: `rr_cache_array`

## Requirements
- R1: After reset every line is invalid, so every lookup misses. `al_busy`, `rd_valid` and `wb_valid` are low, and every set's replacement pointer selects way 0.
- R2: A lookup hits only when a valid line in the set chosen by address bits [OFF_W+SET_W-1:OFF_W] holds the same address with the OFF_W offset bits dropped. On a hit, `lk_way` gives the way and `lk_line` gives the line, with word k in bits [32k+31:32k].
- R3: When more than one valid way of a set holds the same line address, the lookup reports the lowest-numbered way.
- R4: Each set has its own replacement pointer. An allocation into a set takes the way its pointer selects, then moves that pointer up by one, wrapping to 0 after the last way. Pointers of other sets do not move.
- R5: In write-back mode a refill issues WORDS read requests, one at a time, at the line-aligned physical address plus 4·k for k = 0 upward. Each response is stored as word k of the line.
- R6: In write-back mode a write that hits replaces the addressed word. It marks the low half dirty when the word index is below WORDS/2, and the high half otherwise.
- R7: In write-back mode, before the refill, a valid victim writes back only its dirty halves, one word per handshake, in rising word order, at its stored physical address plus 4·k. Low-half-only dirty sends words 0..WORDS/2-1. High-half-only dirty sends WORDS/2..WORDS-1. Both halves dirty sends every word. A clean victim sends nothing.
- R8: `al_done` is high for exactly one cycle, and `al_busy` drops the cycle after it. From then on the new virtual address hits in the chosen way, the line is clean, and the address it replaced misses.
- R9: In write-through mode an allocation raises no write-back or read request, is done in the cycle after it is accepted, leaves the line's data words unchanged, and dirty state is never set.
- R10: While `al_busy` is high, `al_req` and `wr_en` are ignored, and so is `wr_en` in the cycle an allocation is accepted: no line, pointer or word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a valid matching line |
| lk_way | output | WAY_W | Way of the matching line |
| lk_line | output | WORDS·32 | Data words of the matching line |
| wr_en | input | 1 | Write one word of a hitting line |
| wr_addr | input | ADDR_W | Virtual address of the written word |
| wr_data | input | 32 | Word to write |
| al_req | input | 1 | Start an allocation (accepted when idle) |
| al_vaddr | input | ADDR_W | Virtual address to allocate |
| al_paddr | input | ADDR_W | Physical address of the new line |
| al_busy | output | 1 | Allocation in progress |
| al_done | output | 1 | One-cycle pulse as the new line is committed |
| wb_valid | output | 1 | Write-back word request |
| wb_ready | input | 1 | Write-back word accepted |
| wb_addr | output | ADDR_W | Physical address of the written-back word |
| wb_data | output | 32 | Written-back word |
| rd_valid | output | 1 | Refill word read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Physical address of the requested word |
| rd_resp_valid | input | 1 | Read response present |
| rd_resp_data | input | 32 | Read response word |

## Verification
The bench builds two copies with 2 ways, 4 sets and 16-byte lines: one in write-back mode and one in write-through mode. Two ways make the pointer wrap after every second allocation into a set, so eviction of a line written earlier is reached within a few operations. Four words per line give two words per half, so low-only, high-only, both-halves and clean write-back ranges can each be produced and told apart. The write-through copy shows that the same allocation sequence produces no memory traffic and leaves written data in place.

// File: rtl/rr_cache_pkg.sv
package rr_cache_pkg;

   // allocation sequencer states
   typedef enum logic [2:0] {
      AS_IDLE,
      AS_EVICT,
      AS_FILL_REQ,
      AS_FILL_WAIT,
      AS_COMMIT
   } alloc_state_e;

endpackage

// File: rtl/rr_victim_ptr.sv
module rr_victim_ptr #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned SETS  = 4,
   parameter int unsigned WAY_W = 1,
   parameter int unsigned SET_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] sel_set,
   input  logic             adv,
   output logic [WAY_W-1:0] cur_way
);

   logic [SETS-1:0][WAY_W-1:0] ptr_all;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [WAY_W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0;
         end else if (adv && (sel_set == SET_W'(s))) begin
            p_q <= (p_q == WAY_W'(WAYS - 1)) ? '0 : p_q + 1'b1;
         end
      end
      assign ptr_all[s] = p_q;
   end

   assign cur_way = ptr_all[sel_set];

endmodule

// File: rtl/rr_tag_match.sv
module rr_tag_match #(
   parameter int unsigned WAYS   = 2,
   parameter int unsigned LTAG_W = 28,
   parameter int unsigned WAY_W  = 1
) (
   input  logic [WAYS-1:0][LTAG_W-1:0] tags,
   input  logic [WAYS-1:0]             vld,
   input  logic [LTAG_W-1:0]           key,
   output logic                        hit,
   output logic [WAY_W-1:0]            way
);

   // scan downward so the lowest matching way is the one left standing
   always_comb begin
      hit = 1'b0;
      way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (vld[w] && (tags[w] == key)) begin
            hit = 1'b1;
            way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/rr_alloc_ctrl.sv
module rr_alloc_ctrl
   import rr_cache_pkg::*;
#(
   parameter int unsigned WRITE_BACK = 1,
   parameter int unsigned WORDS      = 4,
   parameter int unsigned WORD_W     = 2,
   parameter int unsigned WAY_W      = 1,
   parameter int unsigned SET_W      = 2,
   parameter int unsigned LTAG_W     = 28,
   parameter int unsigned ADDR_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              al_req,
   input  logic [SET_W-1:0]  al_set,
   input  logic [LTAG_W-1:0] al_vtag,
   input  logic [LTAG_W-1:0] al_ptag,
   input  logic [WAY_W-1:0]  vic_way,
   input  logic              vic_vld,
   input  logic [1:0]        vic_dirty,
   input  logic [LTAG_W-1:0] vic_ptag,
   input  logic              wb_ready,
   input  logic              rd_ready,
   input  logic              rd_resp_valid,
   output logic              start,
   output logic              busy,
   output logic              done,
   output logic              fill_we,
   output logic [SET_W-1:0]  set_q,
   output logic [WAY_W-1:0]  way_q,
   output logic [WORD_W-1:0] word_q,
   output logic [LTAG_W-1:0] vtag_q,
   output logic [LTAG_W-1:0] ptag_q,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam int unsigned HALF = WORDS / 2;

   alloc_state_e      st_q;
   logic [WORD_W-1:0] last_q;
   logic [LTAG_W-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= AS_IDLE;
         set_q  <= '0;
         way_q  <= '0;
         word_q <= '0;
         last_q <= '0;
         vtag_q <= '0;
         ptag_q <= '0;
         old_q  <= '0;
      end else begin
         case (st_q)
            AS_IDLE: begin
               if (al_req) begin
                  set_q  <= al_set;
                  way_q  <= vic_way;
                  vtag_q <= al_vtag;
                  ptag_q <= al_ptag;
                  old_q  <= vic_ptag;
                  word_q <= '0;
                  last_q <= WORD_W'(WORDS - 1);
                  if (WRITE_BACK == 0) begin
                     st_q <= AS_COMMIT;
                  end else if (vic_vld && (|vic_dirty)) begin
                     st_q <= AS_EVICT;
                     if (vic_dirty == 2'b10) word_q <= WORD_W'(HALF);
                     if (vic_dirty == 2'b01) last_q <= WORD_W'(HALF - 1);
                  end else begin
                     st_q <= AS_FILL_REQ;
                  end
               end
            end
            AS_EVICT: begin
               if (wb_ready) begin
                  if (word_q == last_q) begin
                     word_q <= '0;
                     st_q   <= AS_FILL_REQ;
                  end else begin
                     word_q <= word_q + 1'b1;
                  end
               end
            end
            AS_FILL_REQ: begin
               if (rd_ready) st_q <= AS_FILL_WAIT;
            end
            AS_FILL_WAIT: begin
               if (rd_resp_valid) begin
                  if (word_q == WORD_W'(WORDS - 1)) begin
                     st_q <= AS_COMMIT;
                  end else begin
                     word_q <= word_q + 1'b1;
                     st_q   <= AS_FILL_REQ;
                  end
               end
            end
            AS_COMMIT: st_q <= AS_IDLE;
            default:   st_q <= AS_IDLE;
         endcase
      end
   end

   assign start    = (st_q == AS_IDLE) && al_req;
   assign busy     = (st_q != AS_IDLE);
   assign done     = (st_q == AS_COMMIT);
   assign fill_we  = (st_q == AS_FILL_WAIT) && rd_resp_valid;
   assign wb_valid = (st_q == AS_EVICT);
   assign wb_addr  = {old_q, word_q, 2'b00};
   assign rd_valid = (st_q == AS_FILL_REQ);
   assign rd_addr  = {ptag_q, word_q, 2'b00};

endmodule

// File: rtl/rr_cache_array.sv
module rr_cache_array #(
   parameter int unsigned WAYS       = 2,
   parameter int unsigned SETS       = 4,
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WRITE_BACK = 1,
   localparam int unsigned WAY_W     = $clog2(WAYS),
   localparam int unsigned WORDS     = LINE_BYTES / 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     lk_addr,
   output logic                  lk_hit,
   output logic [WAY_W-1:0]      lk_way,
   output logic [WORDS*32-1:0]   lk_line,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [31:0]           wr_data,
   input  logic                  al_req,
   input  logic [ADDR_W-1:0]     al_vaddr,
   input  logic [ADDR_W-1:0]     al_paddr,
   output logic                  al_busy,
   output logic                  al_done,
   output logic                  wb_valid,
   input  logic                  wb_ready,
   output logic [ADDR_W-1:0]     wb_addr,
   output logic [31:0]           wb_data,
   output logic                  rd_valid,
   input  logic                  rd_ready,
   output logic [ADDR_W-1:0]     rd_addr,
   input  logic                  rd_resp_valid,
   input  logic [31:0]           rd_resp_data
);

   localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
   localparam int unsigned SET_W  = $clog2(SETS);
   localparam int unsigned WORD_W = OFF_W - 2;
   localparam int unsigned LTAG_W = ADDR_W - OFF_W;

   // elaboration-time parameter checks
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two, at least 8");
   end
   if (ADDR_W <= OFF_W + SET_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the set index and offset");
   end

   // line state
   logic [LTAG_W-1:0] tag_q   [SETS][WAYS];
   logic [LTAG_W-1:0] pa_q    [SETS][WAYS];
   logic              vld_q   [SETS][WAYS];
   logic [1:0]        dirty_q [SETS][WAYS];
   logic [31:0]       data_q  [SETS][WAYS][WORDS];

   // address fields
   logic [SET_W-1:0]  lk_set, wr_set, al_set;
   logic [LTAG_W-1:0] lk_key, wr_key, al_vtag, al_ptag;
   logic [WORD_W-1:0] wr_word;

   assign lk_set  = lk_addr[OFF_W +: SET_W];
   assign lk_key  = lk_addr[ADDR_W-1:OFF_W];
   assign wr_set  = wr_addr[OFF_W +: SET_W];
   assign wr_key  = wr_addr[ADDR_W-1:OFF_W];
   assign wr_word = wr_addr[OFF_W-1:2];
   assign al_set  = al_vaddr[OFF_W +: SET_W];
   assign al_vtag = al_vaddr[ADDR_W-1:OFF_W];
   assign al_ptag = al_paddr[ADDR_W-1:OFF_W];

   logic unused_low_bits;
   assign unused_low_bits = ^{lk_addr[OFF_W-1:0], wr_addr[1:0],
                              al_vaddr[OFF_W-1:0], al_paddr[OFF_W-1:0]};

   // tag rows of the addressed sets
   logic [WAYS-1:0][LTAG_W-1:0] lk_tags, wr_tags;
   logic [WAYS-1:0]             lk_vld, wr_vld;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         lk_tags[w] = tag_q[lk_set][w];
         lk_vld[w]  = vld_q[lk_set][w];
         wr_tags[w] = tag_q[wr_set][w];
         wr_vld[w]  = vld_q[wr_set][w];
      end
   end

   logic             wr_hit;
   logic [WAY_W-1:0] wr_way;

   rr_tag_match #(.WAYS(WAYS), .LTAG_W(LTAG_W), .WAY_W(WAY_W)) u_lk_match (
      .tags(lk_tags), .vld(lk_vld), .key(lk_key), .hit(lk_hit), .way(lk_way)
   );

   rr_tag_match #(.WAYS(WAYS), .LTAG_W(LTAG_W), .WAY_W(WAY_W)) u_wr_match (
      .tags(wr_tags), .vld(wr_vld), .key(wr_key), .hit(wr_hit), .way(wr_way)
   );

   always_comb begin
      for (int k = 0; k < WORDS; k++) begin
         lk_line[k*32 +: 32] = data_q[lk_set][lk_way][k];
      end
   end

   // victim choice and allocation sequencing
   logic              start, commit, fill_we;
   logic [WAY_W-1:0]  vic_way;
   logic [SET_W-1:0]  c_set;
   logic [WAY_W-1:0]  c_way;
   logic [WORD_W-1:0] c_word;
   logic [LTAG_W-1:0] c_vtag, c_ptag;

   rr_victim_ptr #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .sel_set(al_set), .adv(start), .cur_way(vic_way)
   );

   rr_alloc_ctrl #(
      .WRITE_BACK(WRITE_BACK), .WORDS(WORDS), .WORD_W(WORD_W), .WAY_W(WAY_W),
      .SET_W(SET_W), .LTAG_W(LTAG_W), .ADDR_W(ADDR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .al_req(al_req), .al_set(al_set),
      .al_vtag(al_vtag), .al_ptag(al_ptag), .vic_way(vic_way),
      .vic_vld(vld_q[al_set][vic_way]), .vic_dirty(dirty_q[al_set][vic_way]),
      .vic_ptag(pa_q[al_set][vic_way]), .wb_ready(wb_ready), .rd_ready(rd_ready),
      .rd_resp_valid(rd_resp_valid), .start(start), .busy(al_busy), .done(commit),
      .fill_we(fill_we), .set_q(c_set), .way_q(c_way), .word_q(c_word),
      .vtag_q(c_vtag), .ptag_q(c_ptag), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .rd_valid(rd_valid), .rd_addr(rd_addr)
   );

   assign al_done = commit;
   assign wb_data = data_q[c_set][c_way][c_word];

   // write path: blocked while an allocation is accepted or running
   logic wr_ok, mark_dirty, wr_half;
   assign wr_ok   = wr_en && wr_hit && !al_busy && !al_req;
   assign wr_half = wr_word[WORD_W-1];

   if (WRITE_BACK != 0) begin : g_wback
      assign mark_dirty = wr_ok;
   end else begin : g_wthru
      assign mark_dirty = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]   <= '0;
               pa_q[s][w]    <= '0;
               vld_q[s][w]   <= 1'b0;
               dirty_q[s][w] <= 2'b00;
               for (int k = 0; k < WORDS; k++) data_q[s][w][k] <= '0;
            end
         end
      end else begin
         if (start) vld_q[al_set][vic_way] <= 1'b0;
         if (fill_we) data_q[c_set][c_way][c_word] <= rd_resp_data;
         if (commit) begin
            tag_q[c_set][c_way]   <= c_vtag;
            pa_q[c_set][c_way]    <= c_ptag;
            vld_q[c_set][c_way]   <= 1'b1;
            dirty_q[c_set][c_way] <= 2'b00;
         end
         if (wr_ok) data_q[wr_set][wr_way][wr_word] <= wr_data;
         if (mark_dirty) dirty_q[wr_set][wr_way][wr_half] <= 1'b1;
      end
   end

endmodule

// File: rtl/rr_cache_array_chk.sv
module rr_cache_array_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WRITE_BACK = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              al_busy,
   input logic              al_done,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [ADDR_W-1:0] rd_addr
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !al_busy |-> (!rd_valid && !wb_valid));

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

   // R7
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

   // R7
   wb_before_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && rd_valid));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      al_done |=> !al_done);

   // R10
   busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (al_busy && !al_done) |=> al_busy);

   if (WRITE_BACK == 0) begin : g_wt_chk
      // R9
      wt_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(rd_valid || wb_valid));
      // R9
      wt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         al_busy |-> al_done);
   end

endmodule

bind rr_cache_array rr_cache_array_chk #(.ADDR_W(ADDR_W), .WRITE_BACK(WRITE_BACK)) i_chk (
   .clk(clk), .rst_n(rst_n), .al_busy(al_busy), .al_done(al_done),
   .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr)
);

// File: tb/test_rr_cache_array.sv
module test_rr_cache_array;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // write-back copy
   logic [31:0]  lk_addr = '0, wr_addr = '0, wr_data = '0, al_vaddr = '0, al_paddr = '0;
   logic         wr_en = 1'b0, al_req = 1'b0;
   logic         lk_hit, al_busy, al_done, wb_valid, rd_valid;
   logic [0:0]   lk_way;
   logic [127:0] lk_line;
   logic [31:0]  wb_addr, wb_data, rd_addr;
   logic         rd_resp_valid = 1'b0;
   logic [31:0]  rd_resp_data = '0;

   rr_cache_array #(.WAYS(2), .SETS(4), .LINE_BYTES(16), .ADDR_W(32), .WRITE_BACK(1)) i_rr_cache_array (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
      .lk_line(lk_line), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .al_req(al_req), .al_vaddr(al_vaddr), .al_paddr(al_paddr), .al_busy(al_busy),
      .al_done(al_done), .wb_valid(wb_valid), .wb_ready(1'b1), .wb_addr(wb_addr),
      .wb_data(wb_data), .rd_valid(rd_valid), .rd_ready(1'b1), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
   );

   // write-through copy
   logic [31:0]  t_lk_addr = '0, t_wr_addr = '0, t_wr_data = '0, t_al_va = '0, t_al_pa = '0;
   logic         t_wr_en = 1'b0, t_al_req = 1'b0;
   logic         t_lk_hit, t_busy, t_done, t_wb_valid, t_rd_valid;
   logic [0:0]   t_lk_way;
   logic [127:0] t_lk_line;
   logic [31:0]  t_wb_addr, t_wb_data, t_rd_addr;

   rr_cache_array #(.WAYS(2), .SETS(4), .LINE_BYTES(16), .ADDR_W(32), .WRITE_BACK(0)) i_wt (
      .clk(clk), .rst_n(rst_n), .lk_addr(t_lk_addr), .lk_hit(t_lk_hit), .lk_way(t_lk_way),
      .lk_line(t_lk_line), .wr_en(t_wr_en), .wr_addr(t_wr_addr), .wr_data(t_wr_data),
      .al_req(t_al_req), .al_vaddr(t_al_va), .al_paddr(t_al_pa), .al_busy(t_busy),
      .al_done(t_done), .wb_valid(t_wb_valid), .wb_ready(1'b1), .wb_addr(t_wb_addr),
      .wb_data(t_wb_data), .rd_valid(t_rd_valid), .rd_ready(1'b1), .rd_addr(t_rd_addr),
      .rd_resp_valid(1'b0), .rd_resp_data(32'h0)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   // reference model of the line store, kept from the requirements
   logic [31:0] m_va   [4][2];
   logic [31:0] m_pa   [4][2];
   logic        m_vld  [4][2];
   logic [1:0]  m_dirty[4][2];
   logic [31:0] m_data [4][2][4];
   int          m_ptr  [4];

   // scoreboard queues
   logic [31:0] exp_rd[$];
   logic [63:0] exp_wb[$];
   bit wt_traffic = 0;

   // memory responder and monitor
   initial begin
      bit          pend = 0;
      logic [31:0] pend_addr = '0;
      forever begin
         @(negedge clk);
         rd_resp_valid = pend;
         rd_resp_data  = mem_word(pend_addr);
         pend      = rd_valid;
         pend_addr = rd_addr;
         if (rd_valid) begin
            if (exp_rd.size() == 0) chk("R5 unexpected read", rd_addr, 0);
            else chk("R5 read address", rd_addr, exp_rd.pop_front());
         end
         if (wb_valid) begin
            if (exp_wb.size() == 0) chk("R7 unexpected writeback", {wb_addr, wb_data}, 0);
            else chk("R7 writeback word", {wb_addr, wb_data}, exp_wb.pop_front());
         end
         if (t_rd_valid || t_wb_valid) wt_traffic = 1;
      end
   end

   task automatic look(input logic [31:0] va, input string req);
      int s, hw;
      logic [127:0] eline;
      lk_addr = va;
      #1;
      s = int'(va[5:4]);
      hw = -1;
      for (int w = 1; w >= 0; w--)
         if (m_vld[s][w] && m_va[s][w][31:4] == va[31:4]) hw = w;
      chk({req, " hit"}, lk_hit, (hw >= 0));
      if (hw >= 0) begin
         for (int k = 0; k < 4; k++) eline[k*32 +: 32] = m_data[s][hw][k];
         chk({req, " way"}, lk_way, hw);
         chk({req, " line"}, lk_line, eline);
      end
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d);
      int s, hw;
      s = int'(a[5:4]);
      hw = -1;
      for (int w = 1; w >= 0; w--)
         if (m_vld[s][w] && m_va[s][w][31:4] == a[31:4]) hw = w;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (hw >= 0) begin
         m_data[s][hw][a[3:2]] = d;
         m_dirty[s][hw][a[3]]  = 1'b1;
      end
   endtask

   task automatic do_alloc(input logic [31:0] va, input logic [31:0] pa, input bit poke,
                           input logic [31:0] pva, input logic [31:0] pwa);
      int s, w;
      logic [31:0] pal;
      s = int'(va[5:4]);
      w = m_ptr[s];
      pal = {pa[31:4], 4'h0};
      if (m_vld[s][w])
         for (int k = 0; k < 4; k++)
            if (m_dirty[s][w][k/2]) exp_wb.push_back({m_pa[s][w] + 32'(4*k), m_data[s][w][k]});
      for (int k = 0; k < 4; k++) exp_rd.push_back(pal + 32'(4*k));
      @(negedge clk);
      al_vaddr = va; al_paddr = pa; al_req = 1'b1;
      @(negedge clk);
      al_req = 1'b0;
      if (poke) begin
         al_req = 1'b1; al_vaddr = pva; al_paddr = pva;
         wr_en = 1'b1; wr_addr = pwa; wr_data = 32'hBAD0_BAD0;
         @(negedge clk);
         al_req = 1'b0; wr_en = 1'b0;
      end
      while (!al_done) @(negedge clk);
      @(negedge clk);
      chk("R8 done is one cycle", al_done, 0);
      chk("R8 busy drops", al_busy, 0);
      for (int k = 0; k < 4; k++) m_data[s][w][k] = mem_word(pal + 32'(4*k));
      m_va[s][w] = va; m_pa[s][w] = pal; m_vld[s][w] = 1'b1; m_dirty[s][w] = 2'b00;
      m_ptr[s] = (w + 1) % 2;
   endtask

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         m_ptr[s] = 0;
         for (int w = 0; w < 2; w++) begin
            m_va[s][w] = '0; m_pa[s][w] = '0; m_vld[s][w] = 1'b0; m_dirty[s][w] = 2'b00;
            for (int k = 0; k < 4; k++) m_data[s][w][k] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      look(32'h1000_0010, "R1");
      chk("R1 busy", al_busy, 0);
      chk("R1 no read", rd_valid, 0);
      chk("R1 no writeback", wb_valid, 0);

      // R2 R5 first refill, way 0 from the reset pointer (R4)
      do_alloc(32'h1000_0010, 32'h0002_0010, 0, 0, 0);
      look(32'h1000_0018, "R2 R5");
      look(32'h1000_0020, "R2 other set");
      chk("R4 first way", lk_way, 0);

      // R4 second allocation in set 1 goes to way 1
      do_alloc(32'h2000_0014, 32'h0003_0014, 0, 0, 0);
      look(32'h2000_001C, "R4 way1");
      look(32'h1000_0010, "R2 way0 kept");
      look(32'h3000_0010, "R2 miss");

      // R6 write low half, then R7 low-half eviction after the pointer wraps (R4)
      do_write(32'h1000_0014, 32'hDEAD_0001);
      look(32'h1000_0010, "R6 write");
      do_alloc(32'h3000_0010, 32'h0004_0010, 0, 0, 0);
      look(32'h1000_0010, "R8 old gone");
      look(32'h3000_0010, "R8 new line");

      // R7 high half only
      do_write(32'h2000_001C, 32'hBEEF_0003);
      do_alloc(32'h4000_0010, 32'h0005_0010, 0, 0, 0);
      look(32'h4000_0010, "R7 high half");

      // R7 both halves
      do_write(32'h3000_0010, 32'h1111_0000);
      do_write(32'h3000_001C, 32'h3333_0003);
      do_alloc(32'h5000_0010, 32'h0006_0010, 0, 0, 0);
      look(32'h5000_0010, "R7 both halves");

      // R7 clean victim sends nothing
      do_alloc(32'h6000_0010, 32'h0007_0010, 0, 0, 0);
      look(32'h6000_0010, "R7 clean");

      // R3 duplicate line in both ways of set 2
      do_alloc(32'h8000_0020, 32'h0009_0020, 0, 0, 0);
      do_alloc(32'h8000_0020, 32'h000A_0020, 0, 0, 0);
      look(32'h8000_0024, "R3 lowest way");

      // R10 requests while busy are ignored
      do_alloc(32'h9000_0030, 32'h000B_0030, 1, 32'hA000_0030, 32'h6000_0014);
      look(32'hA000_0030, "R10 alloc ignored");
      look(32'h6000_0010, "R10 write ignored");
      do_alloc(32'hB000_0030, 32'h000C_0030, 0, 0, 0);
      look(32'hB000_0030, "R10 R4 pointer moved once");

      chk("R5 all reads seen", exp_rd.size(), 0);
      chk("R7 all writebacks seen", exp_wb.size(), 0);

      // R9 write-through copy
      @(negedge clk);
      t_al_va = 32'h5000_0020; t_al_pa = 32'h1234_5620; t_al_req = 1'b1;
      @(negedge clk);
      t_al_req = 1'b0;
      chk("R9 done next cycle", t_done, 1);
      @(negedge clk);
      chk("R9 busy one cycle", t_busy, 0);
      t_lk_addr = 32'h5000_0024;
      #1;
      chk("R9 hit", t_lk_hit, 1);
      chk("R9 way", t_lk_way, 0);
      chk("R9 no refill", t_lk_line, 128'h0);
      @(negedge clk);
      t_wr_en = 1'b1; t_wr_addr = 32'h5000_0020; t_wr_data = 32'h0000_0011;
      @(negedge clk);
      t_wr_en = 1'b0;
      for (int i = 0; i < 2; i++) begin
         t_al_va = (i == 0) ? 32'h6000_0020 : 32'h7000_0020;
         t_al_req = 1'b1;
         @(negedge clk);
         t_al_req = 1'b0;
         @(negedge clk);
      end
      t_lk_addr = 32'h7000_0020;
      #1;
      chk("R9 realloc way0", t_lk_way, 0);
      chk("R9 data kept", t_lk_line, 128'h11);
      chk("R9 no memory traffic", wt_traffic, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule